// File: doc/BRIEF.md
# Tick-Driven PWM Timer with Bit-Wrapped Period

This block is a single-channel pulse-width generator with a byte-wide register port. An 8-bit counter moves forward by one on each cycle where an external slow tick enable (nominally 32 kHz) is high. The period is not set by a terminal-count compare. Instead, a 2-bit period select `p` names one upper counter bit, bit `7-p`. When the incremented count would set that bit, the counter goes back to zero. The four settings give periods of 128, 64, 32 and 16 ticks. At a 32 kHz tick rate these are 250 Hz, 500 Hz, 1 kHz and 2 kHz. A shorter period leaves fewer counter bits for the duty compare.

The output is high while the counter bits below the wrap bit are less than a 7-bit duty value. Software writes a control register (enable and period select) and a duty register. Neither register is shadowed. A new duty value or period select acts on the next clock edge, and changing the period select does not clear the counter. A small run-state machine has two states. In `ST_IDLE` the output is low and the counter does not advance. In `ST_RUN` the counter counts ticks. The transition `IDLE_TO_RUN` happens on the clock edge after the enable bit is seen set. The transition `RUN_TO_IDLE` happens on the clock edge after the enable bit is seen clear.

Top module: `pwm_tick_timer`

## Requirements
- R1: After reset both registers read 0x00, the counter is zero, the state is `ST_IDLE` and `pwm_out` is low.
- R2: Address 0 is control: bit 7 is enable, bits 1:0 are the period select, and bits 6:2 read as 0. Address 1 is duty: bits 6:0 are stored and bit 7 reads as 0. Any other address reads 0x00. A write to any other address changes no register. A write takes effect on the clock edge where `bus_wr` is sampled high.
- R3: While enabled and in `ST_RUN`, the counter rises by one on each clock edge where `tick_en` is high. It holds its value on every other edge.
- R4: On a tick, if the incremented count has bit `7-p` set, the counter becomes 0 instead. The period is therefore 2^(7-p) ticks.
- R5: In `ST_RUN` with enable set, `pwm_out` is high exactly when (count AND (2^(7-p)-1)) is less than the duty value.
- R6: A duty value equal to or above 2^(7-p) holds `pwm_out` constantly high. With p=0 the largest duty value is 127, so one tick of every 128 is low.
- R7: Writing a new period select does not clear the counter. From a count above the new period, the counter returns to 0 on the first tick whose incremented value sets the new wrap bit.
- R8: A new duty value changes `pwm_out` in the cycle after the write edge, without waiting for a period boundary.
- R9: Clearing enable drives `pwm_out` low in the next cycle and clears the counter. Setting enable takes the state machine to `ST_RUN` one edge later. The output stays low in that cycle, and counting restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse, one clock wide per tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The hardest state to reach from the ports is a counter value above the newly selected period after a period-select change. In that state the compare uses only the low bits, and the wrap fires on the next tick. The bench gets there by counting 20 ticks at the longest period and then switching to shorter periods with no ticks in between. It reads the hidden count by writing neighbouring duty values and watching where `pwm_out` flips. One further tick then shows the early return to zero.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_DUTY = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned PRES_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic [PRES_W-1:0] pres,
    output logic [DATA_W-2:0] duty
);
    import pwm_timer_pkg::*;

    localparam int unsigned EN_BIT = DATA_W - 1;
    localparam int unsigned PAD_W  = DATA_W - 1 - PRES_W;

    logic sel_ctrl;
    logic sel_duty;

    assign sel_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign sel_duty = (bus_addr == ADDR_W'(ADDR_DUTY));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            pres <= '0;
            duty <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) begin
                en   <= bus_wdata[EN_BIT];
                pres <= bus_wdata[PRES_W-1:0];
            end
            if (sel_duty) begin
                duty <= bus_wdata[DATA_W-2:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = {en, {PAD_W{1'b0}}, pres};
        end else if (sel_duty) begin
            bus_rdata = {1'b0, duty};
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRES_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    en,
    input  logic [PRES_W-1:0]       pres,
    output logic [CNT_W-1:0]        cnt,
    output pwm_timer_pkg::run_state_t state
);
    import pwm_timer_pkg::*;

    localparam int unsigned IDX_W = $clog2(CNT_W);

    run_state_t       state_d;
    logic [IDX_W-1:0] wrap_idx;
    logic [CNT_W-1:0] cnt_inc;
    logic             wrap_hit;

    // Next-state logic of the run-state machine
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (en)  state_d = ST_RUN;   // IDLE_TO_RUN
            ST_RUN:  if (!en) state_d = ST_IDLE;  // RUN_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    assign wrap_idx = IDX_W'(CNT_W - 1) - IDX_W'(pres);
    assign cnt_inc  = cnt + CNT_W'(1);
    assign wrap_hit = cnt_inc[wrap_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (state == ST_RUN && tick_en) begin
            cnt <= wrap_hit ? '0 : cnt_inc;
        end
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRES_W = 2
) (
    input  logic [CNT_W-1:0]          cnt,
    input  logic [PRES_W-1:0]         pres,
    input  logic [CNT_W-2:0]          duty,
    input  logic                      en,
    input  pwm_timer_pkg::run_state_t state,
    output logic                      pwm_out
);
    import pwm_timer_pkg::*;

    localparam int unsigned IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] wrap_idx;
    logic [CNT_W-1:0] low_mask;
    logic [CNT_W-1:0] low_bits;

    assign wrap_idx = IDX_W'(CNT_W - 1) - IDX_W'(pres);
    assign low_mask = (CNT_W'(1) << wrap_idx) - CNT_W'(1);
    assign low_bits = cnt & low_mask;

    always_comb begin
        pwm_out = 1'b0;
        unique case (state)
            ST_IDLE: pwm_out = 1'b0;
            ST_RUN:  pwm_out = en && ({1'b0, duty} > low_bits);
            default: pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_tick_timer.sv
module pwm_tick_timer #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRES_W = 2,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              pwm_out
);
    import pwm_timer_pkg::*;

    logic              en;
    logic [PRES_W-1:0] pres;
    logic [CNT_W-2:0]  duty;
    logic [CNT_W-1:0]  cnt;
    run_state_t        state;

    pwm_regs #(.DATA_W(CNT_W), .ADDR_W(ADDR_W), .PRES_W(PRES_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en(en), .pres(pres), .duty(duty)
    );

    pwm_counter #(.CNT_W(CNT_W), .PRES_W(PRES_W)) i_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(en), .pres(pres),
        .cnt(cnt), .state(state)
    );

    pwm_compare #(.CNT_W(CNT_W), .PRES_W(PRES_W)) i_compare (
        .cnt(cnt), .pres(pres), .duty(duty), .en(en), .state(state),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_tick_timer_chk.sv
module pwm_tick_timer_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRES_W = 2,
    parameter int unsigned ADDR_W = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick_en,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [CNT_W-1:0]          bus_rdata,
    input logic                      pwm_out,
    input logic                      en,
    input logic [PRES_W-1:0]         pres,
    input logic [CNT_W-2:0]          duty,
    input logic [CNT_W-1:0]          cnt,
    input pwm_timer_pkg::run_state_t state
);
    import pwm_timer_pkg::*;

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > 1) |-> (bus_rdata == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_en && state == ST_RUN)
        |=> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (!tick_en || state == ST_IDLE)) |=> $stable(cnt));

    p_wrap_bit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick_en && state == ST_RUN)
        |=> !cnt[CNT_W - 1 - int'($past(pres))]);

    p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && int'(duty) >= (1 << (CNT_W - 1 - int'(pres))))
        |-> pwm_out);

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pwm_out);

    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

bind pwm_tick_timer pwm_tick_timer_chk #(.CNT_W(CNT_W), .PRES_W(PRES_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .en(en), .pres(pres),
    .duty(duty), .cnt(cnt), .state(state)
);

// File: tb/test_pwm_tick_timer.sv
module test_pwm_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pwm_tick_timer i_pwm_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_addr = '0;
    endtask

    task automatic pulse_tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // enable with period select p after a clean restart; waits for ST_RUN
    task automatic start(input int p, input int d);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'(d));
        wr(2'd0, 8'h80 | 8'(p));
        @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(2'd0, v); chk("R1", "ctrl after reset", v, 0);
        rd(2'd1, v); chk("R1", "duty after reset", v, 0);
        chk("R1", "pwm_out after reset", int'(pwm_out), 0);
    endtask

    task automatic t_regs();
        int v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R2", "ctrl readback", v, 8'h83);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R2", "duty readback", v, 8'h7F);
        wr(2'd2, 8'hAA);
        wr(2'd3, 8'h00);
        rd(2'd2, v); chk("R2", "unmapped read", v, 0);
        rd(2'd0, v); chk("R2", "ctrl after unmapped write", v, 8'h83);
        rd(2'd1, v); chk("R2", "duty after unmapped write", v, 8'h7F);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    // R3 R4 R5: waveform over two periods must match (i mod period) < duty
    task automatic t_wave(input int p, input int d, input string req);
        int per = 1 << (7 - p);
        int miss = 0;
        start(p, d);
        for (int i = 0; i < 2 * per; i++) begin
            if (int'(pwm_out) != (((i % per) < d) ? 1 : 0)) miss++;
            pulse_tick();
        end
        chk(req, $sformatf("waveform mismatches p=%0d duty=%0d", p, d), miss, 0);
    endtask

    task automatic t_switch();
        start(0, 0);
        for (int i = 0; i < 20; i++) pulse_tick();
        wr(2'd0, 8'h81);
        wr(2'd1, 8'd20);
        chk("R7", "count kept after switch to p=1 (duty 20)", int'(pwm_out), 0);
        wr(2'd1, 8'd21);
        chk("R8", "duty 21 acts without a tick", int'(pwm_out), 1);
        wr(2'd0, 8'h83);
        wr(2'd1, 8'd4);
        chk("R7", "low bits after switch to p=3 (duty 4)", int'(pwm_out), 0);
        wr(2'd1, 8'd5);
        chk("R8", "duty 5 acts without a tick", int'(pwm_out), 1);
        wr(2'd1, 8'd1);
        chk("R7", "count 20 under p=3 gives low", int'(pwm_out), 0);
        pulse_tick();
        chk("R4", "early wrap to 0 from count 20", int'(pwm_out), 1);
    endtask

    task automatic t_enable();
        start(3, 127);
        for (int i = 0; i < 5; i++) pulse_tick();
        chk("R6", "duty 127 at p=3 high", int'(pwm_out), 1);
        wr(2'd0, 8'h03);
        chk("R9", "output low after disable", int'(pwm_out), 0);
        for (int i = 0; i < 5; i++) pulse_tick();
        wr(2'd1, 8'd1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h83;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        chk("R9", "still idle one cycle after enable", int'(pwm_out), 0);
        @(negedge clk);
        chk("R9", "running from count 0 after enable", int'(pwm_out), 1);
        pulse_tick();
        chk("R3", "count 1 with duty 1 is low", int'(pwm_out), 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_wave(0, 3, "R4");
        t_wave(1, 40, "R5");
        t_wave(2, 3, "R3");
        t_wave(3, 7, "R5");
        t_wave(3, 16, "R6");
        t_wave(3, 100, "R6");
        t_wave(0, 127, "R6");
        t_switch();
        t_enable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule